// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous static RAM. The word is made of byte lanes, with two 9-bit lanes by default. An access starts when an address strobe is recognised while the chip is enabled. The block then keeps serving accesses every clock until a strobe arrives with the chip disabled. The two low address bits go into a 2-bit burst counter, so a burst walks through a 4-word group. Each access cycle is a write when a write control is active and a read otherwise. Read data is registered and appears one clock after the edge that launched the read.

The bidirectional data port is split into an input bus, an output bus and a drive enable. The output enable is combinational and gates that drive enable. A sleep input freezes every register and blocks writes while it is high, and the stored data stays intact. The address width is a parameter. Its default gives a 1024-word array that elaborates quickly, and a width of 18 gives the full 256K-word array.

Top module: `sync_burst_sram`

## Requirements
- R1: At a rising edge, a recognised strobe starts an access at the full presented address only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. From then on, every edge is an access cycle until a deselect.
- R2: When `adsp_n`=0 (with `ce1_n`=0) it takes precedence over `adsc_n`. A cycle started by `adsp_n` is always a read, and the write controls are ignored in that cycle.
- R3: While `ce1_n`=1, `adsp_n` is ignored completely. A burst in progress continues as if no strobe were present.
- R4: Starting an access loads address bits [1:0] into the burst counter. The access address is always the upper registered bits followed by the counter.
- R5: In a continuing cycle, `adv_n`=0 steps the counter by one, modulo 4, before the access. `adv_n`=1 repeats the current address.
- R6: A new recognised strobe during a burst abandons it and restarts at the new address.
- R7: `gw_n`=0 in an access cycle writes all lanes, whatever the values of `bwe_n` and `bw_n`.
- R8: When `gw_n`=1 and `bwe_n`=0, each lane i with `bw_n[i]`=0 is written. Lane 0 is bits [8:0] and lane 1 is bits [17:9]. When `bwe_n`=1, `bw_n` has no effect and the cycle is a read.
- R9: Data read at edge k is on `dq_out` after edge k+1. `dq_oe` can be high only during the clock that follows such a fetch edge.
- R10: `oe_n`=1 forces `dq_oe` low combinationally, with no clock edge needed.
- R11: During the first clock after a read is started following a deselected cycle, `dq_oe` stays low even with `oe_n`=0.
- R12: A recognised strobe with any chip enable inactive ends the burst. No accesses occur afterwards, and `dq_oe` stays low.
- R13: While `zz`=1, all registers hold, no write occurs and `dq_oe` is low. When `zz` returns to 0, operation resumes from the held state.
- R14: After reset, no burst is active and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control and output registers |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | Chip enable, active low; also qualifies `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane byte select, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| zz | input | 1 | Sleep, active high |
| dq_in | input | LANE_W*LANES | Write data from the data pins |
| dq_out | output | LANE_W*LANES | Read data toward the data pins |
| dq_oe | output | 1 | Data pin drive enable |

## Verification
The bench goes after four corner cases. The first is the wrap at the end of a 4-word group: a counter that carried into the upper bits would read the next group instead of wrapping. The second is the processor strobe while `ce1_n` is high: a design that honoured it would deselect or restart, and the next beat would be wrong. The third is both strobes low together with a global write: a design that let the controller strobe win would overwrite the word. The fourth is a strobe arriving in the middle of a burst. The bench also checks a byte write with the byte enable off, the blanked first clock after a deselect, and sleep in the middle of a burst. A design that did not fully freeze during sleep would either lose its place in the burst or perform the write attempted while asleep.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

    // Width of the in-group burst counter (4-word groups).
    localparam int unsigned BURST_W = 2;

    // Linear step with natural wrap inside the group.
    function automatic logic [BURST_W-1:0] burst_next(input logic [BURST_W-1:0] c);
        return c + 1'b1;
    endfunction

endpackage

// File: rtl/sburst_decode.sv
module sburst_decode (
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    input  logic adsp_n,
    input  logic adsc_n,
    output logic start,
    output logic proc_start,
    output logic desel
);
    logic p_seen;
    logic c_seen;
    logic en_all;

    always_comb begin
        // Processor strobe only counts with ce1_n low; it masks the controller strobe.
        p_seen     = !adsp_n && !ce1_n;
        c_seen     = !adsc_n && !p_seen;
        en_all     = !ce1_n && ce2 && !ce3_n;
        start      = (p_seen || c_seen) && en_all;
        proc_start = p_seen && en_all;
        desel      = (p_seen || c_seen) && !en_all;
    end
endmodule

// File: rtl/sburst_wmask.sv
module sburst_wmask #(
    parameter int unsigned LANES = 2
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we,
    output logic             wr_req
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Global write overrides; otherwise a lane needs both byte enable and its select.
            assign lane_we[g] = !gw_n || (!bwe_n && !bw_n[g]);
        end
    endgenerate

    assign wr_req = |lane_we;
endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
    import sburst_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zz,
    input  logic              start,
    input  logic              proc_start,
    input  logic              desel,
    input  logic              adv_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              rd_pend,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int unsigned HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic              active;
        logic [HI_W-1:0]   base;
        logic [BURST_W-1:0] cnt;
        logic              rd_pend;
        logic [ADDR_W-1:0] rd_addr;
    } st_t;

    st_t  st_d, st_q;
    logic acc;
    logic is_wr;

    always_comb begin
        st_d     = st_q;
        acc      = 1'b0;
        acc_addr = {st_q.base, st_q.cnt};
        if (start) begin
            st_d.active = 1'b1;
            st_d.base   = addr[ADDR_W-1:BURST_W];
            st_d.cnt    = addr[BURST_W-1:0];
            acc         = 1'b1;
            acc_addr    = addr;
        end else if (desel) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            acc = 1'b1;
            if (!adv_n) begin
                st_d.cnt = burst_next(st_q.cnt);
            end
            acc_addr = {st_q.base, st_d.cnt};
        end
        // A processor-strobe start is always a read.
        is_wr        = wr_req && !proc_start;
        acc_we       = acc && is_wr && !zz;
        st_d.rd_pend = acc && !is_wr;
        st_d.rd_addr = acc_addr;
        if (zz) begin
            st_d = st_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_pend = st_q.rd_pend;
    assign rd_addr = st_q.rd_addr;

    // R1 and R4: a start captures the full address into base and counter.
    a_r4_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !zz) |=> (st_q.cnt == $past(addr[BURST_W-1:0]) &&
                            st_q.base == $past(addr[ADDR_W-1:BURST_W]) && st_q.active));

    a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !desel && st_q.active && !adv_n && !zz) |=>
            (st_q.cnt == $past(st_q.cnt) + 1'b1));

    a_r2_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start && !zz) |=> st_q.rd_pend);

    a_r12_desel_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (desel && !zz) |=> !st_q.active);

    a_r13_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        zz |=> $stable(st_q));
endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     zz,
    input  logic                     oe_n,
    input  logic                     we,
    input  logic [LANES-1:0]         lane_we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANE_W*LANES-1:0]  wdata,
    input  logic                     rd_pend,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANE_W*LANES-1:0]  dq_out,
    output logic                     dq_oe
);
    localparam int unsigned DW    = LANE_W * LANES;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } out_t;

    logic [DW-1:0] mem [DEPTH];
    out_t          out_d, out_q;

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_we[i]) begin
                    mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_comb begin
        out_d = out_q;
        if (!zz) begin
            out_d.vld = rd_pend;
            if (rd_pend) begin
                out_d.data = mem[rd_addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dq_out = out_q.data;
    assign dq_oe  = out_q.vld && !oe_n && !zz;

    a_r9_drive_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.vld |-> $past(rd_pend));

    a_r13_no_write_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        zz |-> !we);

    a_r7_lanes_land: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (&lane_we)) |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    zz,
    input  logic [LANE_W*LANES-1:0] dq_in,
    output logic [LANE_W*LANES-1:0] dq_out,
    output logic                    dq_oe
);
    logic              start;
    logic              proc_start;
    logic              desel;
    logic [LANES-1:0]  lane_we;
    logic              wr_req;
    logic              acc_we;
    logic [ADDR_W-1:0] acc_addr;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr;

    sburst_decode u_decode (
        .ce1_n      (ce1_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .adsp_n     (adsp_n),
        .adsc_n     (adsc_n),
        .start      (start),
        .proc_start (proc_start),
        .desel      (desel)
    );

    sburst_wmask #(.LANES(LANES)) u_wmask (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we),
        .wr_req  (wr_req)
    );

    sburst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .zz         (zz),
        .start      (start),
        .proc_start (proc_start),
        .desel      (desel),
        .adv_n      (adv_n),
        .wr_req     (wr_req),
        .addr       (addr),
        .acc_we     (acc_we),
        .acc_addr   (acc_addr),
        .rd_pend    (rd_pend),
        .rd_addr    (rd_addr)
    );

    sburst_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .zz      (zz),
        .oe_n    (oe_n),
        .we      (acc_we),
        .lane_we (lane_we),
        .waddr   (acc_addr),
        .wdata   (dq_in),
        .rd_pend (rd_pend),
        .rd_addr (rd_addr),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    // R10: output enable high never lets the pins drive.
    a_r10_oe_high_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);
endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
    localparam int unsigned AW = 6;
    localparam int unsigned DW = 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, zz;
    logic [1:0]    bw_n;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int nchk = 0;
    int nerr = 0;
    logic [DW-1:0] ref_mem [64];

    sync_burst_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_in();
        addr = '0; ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1;
        adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11; oe_n = 0; zz = 0; dq_in = '0;
    endtask

    task automatic ref_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] lanes);
        if (lanes[0]) ref_mem[a][8:0]  = d[8:0];
        if (lanes[1]) ref_mem[a][17:9] = d[17:9];
    endtask

    function automatic logic [AW-1:0] grp(input logic [AW-1:0] s, input int i);
        logic [1:0] lo;
        lo = s[1:0] + 2'(i);
        return {s[AW-1:2], lo};
    endfunction

    task automatic desel();
        adsc_n = 0; ce2 = 0; adv_n = 1; gw_n = 1; bwe_n = 1;
        tick();
        adsc_n = 1; ce2 = 1;
    endtask

    // Controller-strobe read burst from s, checking n beats.
    task automatic rd_burst(input logic [AW-1:0] s, input int n, input string tag);
        adsc_n = 0; addr = s;
        tick();
        chk("R11 first clock blank", {17'd0, dq_oe}, 18'd0);
        adsc_n = 1; adv_n = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            chk(tag, {17'd0, dq_oe}, 18'd1);
            chk(tag, dq_out, ref_mem[grp(s, i)]);
        end
        desel();
    endtask

    task automatic t_reset();
        idle_in();
        rst_n = 0;
        repeat (3) tick();
        chk("R14 reset drive", {17'd0, dq_oe}, 18'd0);
        rst_n = 1;
        tick();
        tick();
        chk("R14 idle after reset", {17'd0, dq_oe}, 18'd0);
    endtask

    task automatic t_write_burst_wrap();
        adsc_n = 0; addr = 6'h12; gw_n = 0; dq_in = 18'h0A1A1;
        ref_wr(6'h12, dq_in, 2'b11);
        tick();
        adsc_n = 1; adv_n = 0; dq_in = 18'h1B2B2;
        ref_wr(6'h13, dq_in, 2'b11);
        tick();
        dq_in = 18'h2C3C3;
        ref_wr(6'h10, dq_in, 2'b11);
        tick();
        desel();
        rd_burst(6'h12, 1, "R1 R4 start beat");
        rd_burst(6'h12, 3, "R5 linear wrap");
    endtask

    task automatic t_byte_lanes();
        adsc_n = 0; addr = 6'h20; gw_n = 0; dq_in = 18'h15555;
        ref_wr(6'h20, dq_in, 2'b11);
        tick();
        adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 0; bw_n = 2'b10; dq_in = 18'h3FFFF;
        ref_wr(6'h20, dq_in, 2'b01);
        tick();
        bw_n = 2'b01; dq_in = 18'h00000;
        ref_wr(6'h20, dq_in, 2'b10);
        tick();
        bwe_n = 1; bw_n = 2'b00; dq_in = 18'h12345;
        tick();
        adv_n = 0; gw_n = 0; bwe_n = 0; bw_n = 2'b11; dq_in = 18'h2ABCD;
        ref_wr(6'h21, dq_in, 2'b11);
        tick();
        gw_n = 1; bwe_n = 1;
        desel();
        chk("R8 lane merge model", ref_mem[6'h20], 18'h001FF);
        rd_burst(6'h20, 1, "R8 byte lanes");
        rd_burst(6'h21, 1, "R7 global write");
    endtask

    task automatic t_adv_hold();
        adsc_n = 0; addr = 6'h12;
        tick();
        adsc_n = 1; adv_n = 1;
        tick();
        chk("R5 hold beat0", dq_out, ref_mem[6'h12]);
        tick();
        chk("R5 hold repeat", dq_out, ref_mem[6'h12]);
        adv_n = 0;
        tick();
        chk("R5 hold then step", dq_out, ref_mem[6'h12]);
        tick();
        chk("R5 stepped", dq_out, ref_mem[6'h13]);
        desel();
    endtask

    task automatic t_proc_priority();
        adsp_n = 0; adsc_n = 0; addr = 6'h12; gw_n = 0; dq_in = 18'h0BAD0;
        tick();
        adsp_n = 1; adsc_n = 1; gw_n = 1; adv_n = 1;
        tick();
        chk("R2 proc start reads", {17'd0, dq_oe}, 18'd1);
        chk("R2 proc start data", dq_out, ref_mem[6'h12]);
        desel();
        rd_burst(6'h12, 1, "R2 no write");
    endtask

    task automatic t_ce1_masks_adsp();
        adsc_n = 0; addr = 6'h12;
        tick();
        adsc_n = 1; adv_n = 0;
        tick();
        chk("R3 beat0", dq_out, ref_mem[6'h12]);
        ce1_n = 1; adsp_n = 0; addr = 6'h30;
        tick();
        chk("R3 beat1", dq_out, ref_mem[6'h13]);
        ce1_n = 0; adsp_n = 1;
        tick();
        chk("R3 burst continues", dq_out, ref_mem[6'h10]);
        chk("R3 still driven", {17'd0, dq_oe}, 18'd1);
        desel();
    endtask

    task automatic t_abort();
        adsc_n = 0; addr = 6'h12;
        tick();
        adsc_n = 1; adv_n = 0;
        tick();
        chk("R6 beat0", dq_out, ref_mem[6'h12]);
        adsc_n = 0; addr = 6'h20;
        tick();
        chk("R6 beat before restart", dq_out, ref_mem[6'h13]);
        adsc_n = 1;
        tick();
        chk("R6 restart addr", dq_out, ref_mem[6'h20]);
        tick();
        chk("R6 restart next", dq_out, ref_mem[6'h21]);
        desel();
    endtask

    task automatic t_oe();
        adsc_n = 0; addr = 6'h12;
        tick();
        adsc_n = 1; adv_n = 1;
        tick();
        chk("R10 driven with oe low", {17'd0, dq_oe}, 18'd1);
        oe_n = 1;
        #1;
        chk("R10 oe high undriven", {17'd0, dq_oe}, 18'd0);
        oe_n = 0;
        #1;
        chk("R10 oe low again", {17'd0, dq_oe}, 18'd1);
        desel();
    endtask

    task automatic t_deselect();
        adsc_n = 0; addr = 6'h12;
        tick();
        adsc_n = 1; adv_n = 0;
        tick();
        adsp_n = 0; ce3_n = 1;
        tick();
        chk("R12 last beat", dq_out, ref_mem[6'h13]);
        adsp_n = 1; ce3_n = 0;
        tick();
        chk("R12 undriven after deselect", {17'd0, dq_oe}, 18'd0);
        tick();
        chk("R12 no burst resumes", {17'd0, dq_oe}, 18'd0);
        adv_n = 1;
    endtask

    task automatic t_sleep();
        adsc_n = 0; addr = 6'h12;
        tick();
        adsc_n = 1; adv_n = 0;
        tick();
        chk("R13 beat0", dq_out, ref_mem[6'h12]);
        zz = 1;
        #1;
        chk("R13 asleep undriven", {17'd0, dq_oe}, 18'd0);
        adsc_n = 0; addr = 6'h20; gw_n = 0; dq_in = 18'h3DEAD;
        tick();
        tick();
        chk("R13 still undriven", {17'd0, dq_oe}, 18'd0);
        adsc_n = 1; gw_n = 1; adv_n = 0; zz = 0;
        #1;
        chk("R13 held output", dq_out, ref_mem[6'h12]);
        chk("R13 drive restored", {17'd0, dq_oe}, 18'd1);
        tick();
        chk("R13 resume beat1", dq_out, ref_mem[6'h13]);
        tick();
        chk("R13 resume beat2", dq_out, ref_mem[6'h10]);
        desel();
        rd_burst(6'h20, 1, "R13 no write while asleep");
    endtask

    initial begin : watchdog
        #1_000_000;
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_write_burst_wrap();
        t_byte_lanes();
        t_adv_hold();
        t_proc_priority();
        t_ce1_masks_adsp();
        t_abort();
        t_oe();
        t_deselect();
        t_sleep();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule